// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Group

This block gathers hardware event pulses into three 32-bit interrupt cause groups (receive, transmit and miscellaneous) and merges them into a single level interrupt line. Each group latches events into a cause register. A mask decides which cause bits reach the summary. A per-bit clear-mode register picks, bit by bit, whether a cause bit is cleared by reading the cause register or by writing a 1 to it. Software can also raise cause bits itself, and can set or clear mask bits through separate strobe registers, so no read-modify-write is needed.

A summary register holds one sticky bit per group. A bit is set while any unmasked cause bit of that group is set, and reading the register clears it. A separate 3-bit software mask gates the summary bits before they drive the interrupt output. Software reaches every register through a simple single-cycle read/write bus. Read data appears one cycle after the read strobe, and any clear triggered by the read takes effect on that same clock edge.

Top module: `irq_cause_hub`

## Requirements
- R1: After reset every cause bit is 0, every group mask bit is 1, every clear-mode bit is 0, the summary register is 0, the software summary mask is 3'b111 and irq_o is 0.
- R2: A 1 on an event input bit, or a 1 written to the group's set register (register 1), sets the matching cause bit on the next clock edge.
- R3: Writing to the mask-set register (register 2) sets the mask bits where the write data is 1. Writing to the mask-clear register (register 3) clears the mask bits where the write data is 1. Zero data bits leave the mask unchanged. The mask-value register (register 6) reads back the mask.
- R4: The masked-cause register (register 5) reads cause AND NOT mask. Reading it, or reading the mask-value register, changes no state.
- R5: A read of the cause register (register 0) returns the value before the read and clears every cause bit whose clear-mode bit (register 4, read/write) is 1. Bits whose clear-mode bit is 0 survive the read.
- R6: A write to the cause register clears the bits where the data is 1 and the clear-mode bit is 0. Bits whose clear-mode bit is 1, and bits where the data is 0, are not affected.
- R7: An event that arrives in the same cycle as a clear by read or by write wins: the cause bit stays set.
- R8: Summary bit 0 (receive), bit 1 (transmit) or bit 2 (miscellaneous) becomes set one cycle after that group has an unmasked cause bit. The summary bit stays set until a read of the summary register (block 3, register 0) clears it, and it is set again if the group is still active.
- R9: irq_o is a level that is 1 whenever some summary bit is set and its bit in the software summary mask (block 3, register 1; bits [2:0], 1 = disabled, zero-extended on read) is 0.
- R10: Address bits [5:3] select a block: 0 = receive, 1 = transmit, 2 = miscellaneous, 3 = summary. Address bits [2:0] select the register. Unused addresses read as 0, and writes to them are ignored. The set and mask-strobe registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register address {block, register} |
| wdata_i | input | CAUSE_W | Write data |
| rdata_o | output | CAUSE_W | Read data, valid the cycle after rd_en_i |
| rx_evt_i | input | CAUSE_W | Receive group event pulses |
| tx_evt_i | input | CAUSE_W | Transmit group event pulses |
| misc_evt_i | input | CAUSE_W | Miscellaneous group event pulses |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with CAUSE_W = 8. At that width it can drive every cause bit of all three groups through the event path and through both clear flavours, one bit at a time, and check each step against shifted constants. Clear-mode and mask patterns with mixed halves (0x0F, 0xF1, 0xA5) cover the read-clear, write-clear and masked-cause rules on the same bits. Per-group summary and software-mask sweeps cover every summary bit position and its gating of irq_o. The event-versus-clear collisions are driven on single chosen bits in both clear modes.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int NUM_GRP  = 3;
  localparam int ADDR_W   = 6;
  localparam int GRP_RX   = 0;
  localparam int GRP_TX   = 1;
  localparam int GRP_MISC = 2;
  localparam logic [2:0] BLK_SUMM = 3'd3;

  typedef enum logic [2:0] {
    REG_CAUSE  = 3'd0,
    REG_SET    = 3'd1,
    REG_MSET   = 3'd2,
    REG_MCLR   = 3'd3,
    REG_MODE   = 3'd4,
    REG_MCAUSE = 3'd5,
    REG_MVAL   = 3'd6
  } grp_reg_e;

  localparam logic [2:0] SREG_CAUSE = 3'd0;
  localparam logic [2:0] SREG_MASK  = 3'd1;
endpackage

// File: rtl/irq_cause_grp.sv
module irq_cause_grp
  import irq_cause_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] evt_i,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [2:0]         reg_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] rdata_o,
  output logic               active_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [CAUSE_W-1:0] mask_o,
  output logic [CAUSE_W-1:0] mode_o
);
  logic [CAUSE_W-1:0] cause_q, mask_q, mode_q, clr, set;
  logic wr_cause, rd_cause, wr_set, wr_mset, wr_mclr, wr_mode;

  assign wr_cause = sel_i & wr_i & (reg_i == REG_CAUSE);
  assign rd_cause = sel_i & rd_i & (reg_i == REG_CAUSE);
  assign wr_set   = sel_i & wr_i & (reg_i == REG_SET);
  assign wr_mset  = sel_i & wr_i & (reg_i == REG_MSET);
  assign wr_mclr  = sel_i & wr_i & (reg_i == REG_MCLR);
  assign wr_mode  = sel_i & wr_i & (reg_i == REG_MODE);

  always_comb begin
    clr = '0;
    if (wr_cause) clr = clr | (wdata_i & ~mode_q);
    if (rd_cause) clr = clr | mode_q;
    set = evt_i | (wr_set ? wdata_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      // set after clear: a colliding event survives
      cause_q <= (cause_q & ~clr) | set;
      if (wr_mset)      mask_q <= mask_q | wdata_i;
      else if (wr_mclr) mask_q <= mask_q & ~wdata_i;
      if (wr_mode)      mode_q <= wdata_i;
    end
  end

  always_comb begin
    case (reg_i)
      REG_CAUSE:  rdata_o = cause_q;
      REG_MODE:   rdata_o = mode_q;
      REG_MCAUSE: rdata_o = cause_q & ~mask_q;
      REG_MVAL:   rdata_o = mask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign active_o = |(cause_q & ~mask_q);
  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_cause_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [2:0]         reg_i,
  input  logic [NUM_GRP-1:0] wdata_i,
  input  logic [NUM_GRP-1:0] active_i,
  output logic [NUM_GRP-1:0] rdata_o,
  output logic [NUM_GRP-1:0] summ_o,
  output logic [NUM_GRP-1:0] swmask_o,
  output logic               irq_o
);
  logic [NUM_GRP-1:0] summ_q, swmask_q;
  logic rd_summ, wr_mask;

  assign rd_summ = sel_i & rd_i & (reg_i == SREG_CAUSE);
  assign wr_mask = sel_i & wr_i & (reg_i == SREG_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      summ_q   <= '0;
      swmask_q <= '1;
    end else begin
      summ_q <= (rd_summ ? '0 : summ_q) | active_i;
      if (wr_mask) swmask_q <= wdata_i;
    end
  end

  always_comb begin
    case (reg_i)
      SREG_CAUSE: rdata_o = summ_q;
      SREG_MASK:  rdata_o = swmask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o    = |(summ_q & ~swmask_q);
  assign summ_o   = summ_q;
  assign swmask_o = swmask_q;
endmodule

// File: rtl/irq_cause_hub.sv
module irq_cause_hub
  import irq_cause_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] rdata_o,
  input  logic [CAUSE_W-1:0] rx_evt_i,
  input  logic [CAUSE_W-1:0] tx_evt_i,
  input  logic [CAUSE_W-1:0] misc_evt_i,
  output logic               irq_o
);
  localparam int PAD_W = CAUSE_W - NUM_GRP;

  logic [NUM_GRP-1:0][CAUSE_W-1:0] evt_all, grp_rdata, cause_all, mask_all, mode_all;
  logic [NUM_GRP-1:0] active, summ, swmask, summ_rdata;
  logic [2:0] blk, rsel;
  logic [CAUSE_W-1:0] rd_mux;

  assign evt_all[GRP_RX]   = rx_evt_i;
  assign evt_all[GRP_TX]   = tx_evt_i;
  assign evt_all[GRP_MISC] = misc_evt_i;
  assign blk  = addr_i[5:3];
  assign rsel = addr_i[2:0];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irq_cause_grp #(.CAUSE_W(CAUSE_W)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_all[g]),
      .sel_i    (blk == 3'(g)),
      .wr_i     (wr_en_i),
      .rd_i     (rd_en_i),
      .reg_i    (rsel),
      .wdata_i  (wdata_i),
      .rdata_o  (grp_rdata[g]),
      .active_o (active[g]),
      .cause_o  (cause_all[g]),
      .mask_o   (mask_all[g]),
      .mode_o   (mode_all[g])
    );
  end

  irq_summary u_summ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (blk == BLK_SUMM),
    .wr_i     (wr_en_i),
    .rd_i     (rd_en_i),
    .reg_i    (rsel),
    .wdata_i  (wdata_i[NUM_GRP-1:0]),
    .active_i (active),
    .rdata_o  (summ_rdata),
    .summ_o   (summ),
    .swmask_o (swmask),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (blk)
      3'd0:     rd_mux = grp_rdata[GRP_RX];
      3'd1:     rd_mux = grp_rdata[GRP_TX];
      3'd2:     rd_mux = grp_rdata[GRP_MISC];
      BLK_SUMM: rd_mux = {{PAD_W{1'b0}}, summ_rdata};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_cause_hub_chk.sv
module irq_cause_hub_chk
  import irq_cause_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            wr_en_i,
  input logic                            rd_en_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [NUM_GRP-1:0][CAUSE_W-1:0] evt,
  input logic [NUM_GRP-1:0][CAUSE_W-1:0] cause,
  input logic [NUM_GRP-1:0][CAUSE_W-1:0] mask,
  input logic [NUM_GRP-1:0][CAUSE_W-1:0] mode,
  input logic [NUM_GRP-1:0]              summ,
  input logic                            irq_o
);
  logic any_active;
  assign any_active = ((cause[0] & ~mask[0]) != '0) || ((cause[1] & ~mask[1]) != '0) ||
                      ((cause[2] & ~mask[2]) != '0);

  // R3
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask));

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(any_active) || $past(wr_en_i)));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] CAUSE_A = 6'(g * 8);

    // R2 R7
    evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt[g] != '0) |=> ((cause[g] & $past(evt[g])) == $past(evt[g])));

    // R5
    cor_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && !wr_en_i && addr_i == CAUSE_A)
        |=> ((cause[g] & $past(mode[g] & ~evt[g])) == '0));

    // R6
    cor_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !rd_en_i && addr_i == CAUSE_A)
        |=> ((cause[g] & $past(cause[g] & mode[g])) == $past(cause[g] & mode[g])));

    // R8
    summ_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause[g] & ~mask[g]) != '0) |=> summ[g]);
  end
endmodule

bind irq_cause_hub irq_cause_hub_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .evt     (evt_all),
  .cause   (cause_all),
  .mask    (mask_all),
  .mode    (mode_all),
  .summ    (summ),
  .irq_o   (irq_o)
);

// File: tb/irq_cause_hub_bench.sv
module irq_cause_hub_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic [2:0][W-1:0] evt = '0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_hub #(.CAUSE_W(W)) u_irq_cause_hub (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rx_evt_i(evt[0]), .tx_evt_i(evt[1]), .misc_evt_i(evt[2]), .irq_o(irq));

  function automatic logic [5:0] ad(int blk, int r);
    return 6'(blk * 8 + r);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [5:0] a, logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rdchk(string req, logic [5:0] a, logic [W-1:0] exp);
    logic [W-1:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(int g, logic [W-1:0] v);
    @(negedge clk); evt[g] = v;
    @(negedge clk); evt[g] = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] d;
    do_reset();
    // R1 reset state
    for (int g = 0; g < 3; g++) begin
      rdchk("R1", ad(g, 0), 8'h00);
      rdchk("R1", ad(g, 6), 8'hFF);
      rdchk("R1", ad(g, 4), 8'h00);
      rdchk("R4", ad(g, 5), 8'h00);
    end
    rdchk("R1", ad(3, 0), 8'h00);
    rdchk("R1", ad(3, 1), 8'h07);
    chk("R1", W'(irq), 8'h00);

    // R2 R5 R6: per-bit event sweep, write-1-to-clear mode
    for (int g = 0; g < 3; g++) begin
      for (int b = 0; b < W; b++) begin
        pulse(g, 8'(1 << b));
        rdchk("R2", ad(g, 0), 8'(1 << b));
        rdchk("R5", ad(g, 0), 8'(1 << b));
        wr(ad(g, 0), 8'h00);
        rdchk("R6", ad(g, 0), 8'(1 << b));
        wr(ad(g, 0), 8'(1 << b));
        rdchk("R6", ad(g, 0), 8'h00);
      end
    end

    for (int g = 0; g < 3; g++) begin
      // R2 software set, R3 mask strobes, R4 masked view
      wr(ad(g, 1), 8'hA5);
      rdchk("R2", ad(g, 0), 8'hA5);
      wr(ad(g, 3), 8'h0F);
      rdchk("R3", ad(g, 6), 8'hF0);
      wr(ad(g, 2), 8'h01);
      rdchk("R3", ad(g, 6), 8'hF1);
      wr(ad(g, 3), 8'h00);
      rdchk("R3", ad(g, 6), 8'hF1);
      rdchk("R4", ad(g, 5), 8'h04);
      rdchk("R4", ad(g, 5), 8'h04);
      rdchk("R4", ad(g, 0), 8'hA5);
      // R5 clear on read for mode-1 bits
      wr(ad(g, 4), 8'h0F);
      rdchk("R10", ad(g, 4), 8'h0F);
      rdchk("R5", ad(g, 0), 8'hA5);
      rdchk("R5", ad(g, 0), 8'hA0);
      // R6 write clear hits mode-0 bits only
      wr(ad(g, 0), 8'hFF);
      rdchk("R6", ad(g, 4), 8'h0F);
      wr(ad(g, 1), 8'h05);
      wr(ad(g, 0), 8'h05);
      rdchk("R6", ad(g, 0), 8'h05);
      rdchk("R5", ad(g, 0), 8'h00);
      // R7 event beats write clear
      wr(ad(g, 1), 8'h20);
      @(negedge clk); addr = ad(g, 0); wdata = 8'h20; wr_en = 1'b1; evt[g] = 8'h20;
      @(negedge clk); wr_en = 1'b0; evt[g] = '0;
      rdchk("R7", ad(g, 0), 8'h20);
      wr(ad(g, 0), 8'h20);
      // R7 event beats read clear
      wr(ad(g, 1), 8'h08);
      @(negedge clk); addr = ad(g, 0); rd_en = 1'b1; evt[g] = 8'h08;
      @(negedge clk); rd_en = 1'b0; evt[g] = '0;
      rdchk("R7", ad(g, 0), 8'h08);
      rdchk("R7", ad(g, 0), 8'h00);
      // R10 unused and strobe registers
      rdchk("R10", ad(g, 7), 8'h00);
      rdchk("R10", ad(g, 1), 8'h00);
    end
    rdchk("R10", ad(4, 0), 8'h00);
    rdchk("R10", ad(3, 5), 8'h00);

    // R8 R9 summary per group
    for (int g = 0; g < 3; g++) begin
      do_reset();
      wr(ad(g, 1), 8'h04);
      idle(2);
      rdchk("R8", ad(3, 0), 8'h00);
      wr(ad(g, 3), 8'h04);
      idle(2);
      chk("R9", W'(irq), 8'h00);
      rdchk("R8", ad(3, 0), 8'(1 << g));
      wr(ad(3, 1), 8'hF8);
      idle(1);
      chk("R9", W'(irq), 8'h01);
      rdchk("R9", ad(3, 1), 8'h00);
      wr(ad(g, 0), 8'h04);
      idle(1);
      rdchk("R8", ad(3, 0), 8'(1 << g));
      rdchk("R8", ad(3, 0), 8'h00);
      chk("R9", W'(irq), 8'h00);
    end

    // R9 software mask selects groups
    do_reset();
    wr(ad(0, 1), 8'h01);
    wr(ad(0, 3), 8'h01);
    wr(ad(3, 1), 8'hFD);
    idle(2);
    chk("R9", W'(irq), 8'h00);
    wr(ad(3, 1), 8'hFE);
    idle(1);
    chk("R9", W'(irq), 8'h01);
    wr(ad(1, 1), 8'h80);
    wr(ad(1, 3), 8'h80);
    pulse(2, 8'h40);
    wr(ad(2, 3), 8'h40);
    idle(2);
    rdchk("R8", ad(3, 0), 8'h07);
    rdchk("R4", ad(2, 5), 8'h40);
    d = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule